// File: doc/BRIEF.md
# Nonuniform Carry-Select Adder

This block adds two 32-bit operands and an incoming carry, producing a 32-bit sum and a carry-out. The word is split into four fields whose widths grow toward the top: two 4-bit fields, then an 8-bit field, then a 16-bit field. The lowest field is a plain ripple adder fed by the external carry-in. Every field above it runs two ripple adders side by side, one assuming a carry-in of zero and one assuming a carry-in of one. The real carry coming out of the field below then picks one of the two sums and its matching carry-out.

The effect is that the long ripple inside each wide field runs in parallel with the carries settling below it. The critical path becomes one short ripple plus a chain of three 2:1 selects, rather than a 32-bit ripple. The block has no state and no clock. A caller uses it like any combinational adder, reading the result in the same cycle that it presents the operands.

Top module: `csel_adder32`

## Requirements
- R1: For every a, b and cin, the 33-bit value {cout, sum} equals a + b + cin computed as an unsigned 33-bit addition.
- R2: sum[3:0] depends only on a[3:0], b[3:0] and cin, and equals the low four bits of a[3:0] + b[3:0] + cin. Changing a[31:4] or b[31:4] leaves sum[3:0] unchanged.
- R3: A carry produced in one field reaches the next field across each of the boundaries at bits 4, 8 and 16. For example, 0x0000000F + 0x00000001 gives 0x00000010, and 0x000000FF + 0x00000001 gives 0x00000100.
- R4: Each upper field delivers the sum of its own operand bits plus the actual carry out of the field below. A carry that must ripple through every bit of the 16-bit field, as in 0x0000FFFF + 0x00000001 giving 0x00010000, is handled correctly.
- R5: cout is 1 exactly when the unsigned sum a + b + cin is 2^32 or more. The upper-field carry-out selected by the real carry drives it.
- R6: 0xFFFFFFFF + 0x00000001 with cin = 0 gives sum 0x00000000 and cout 1.
- R7: 0xFFFFFFFF + 0x00000000 with cin = 1 gives sum 0x00000000 and cout 1.
- R8: Zero operands with cin = 1 give sum 0x00000001 and cout 0. Zero operands with cin = 0 give all-zero outputs.
- R9: The block is purely combinational. sum and cout follow a change of a, b or cin within the same clock cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a    | input     | 32    | First operand |
| b    | input     | 32    | Second operand |
| cin  | input     | 1     | Incoming carry added at bit 0 |
| sum  | output    | 32    | Low 32 bits of a + b + cin |
| cout | output    | 1     | Carry out of bit 31 |

## Verification
Every result of this block is due zero cycles after its stimulus, because no register lies between the operands and the outputs. The bench changes a, b and cin just after a rising clock edge. It reads sum and cout at the following falling edge, half a period later, and compares them with a behavioural 33-bit addition. Corner vectors that push a carry across each field boundary and through the whole word come first. Random operand pairs with both carry-in values follow.

// File: rtl/csel_adder_pkg.sv
package csel_adder_pkg;

  // Width of field k: the two lowest fields share the base width,
  // and each field after that doubles.
  function automatic int field_width(input int k, input int base);
    if (k < 2) return base;
    return base << (k - 1);
  endfunction

  // Position of the lowest bit of field k.
  function automatic int field_lsb(input int k, input int base);
    if (k == 0) return 0;
    return base << (k - 1);
  endfunction

  // Total word width for a given field count.
  function automatic int word_width(input int nfields, input int base);
    return base << (nfields - 1);
  endfunction

endpackage

// File: rtl/csel_ripple.sv
module csel_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);

  logic [W:0]   carry;
  logic [W-1:0] gen;
  logic [W-1:0] prop;

  assign carry[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gen[i]      = x[i] & y[i];
    assign prop[i]     = x[i] ^ y[i];
    assign s[i]        = prop[i] ^ carry[i];
    assign carry[i+1]  = gen[i] | (prop[i] & carry[i]);
  end

  assign co = carry[W];

endmodule

// File: rtl/csel_dual_field.sv
module csel_dual_field #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s_c0,
  output logic         co_c0,
  output logic [W-1:0] s_c1,
  output logic         co_c1
);

  csel_ripple #(.W(W)) u_zero (
    .x (x),
    .y (y),
    .ci(1'b0),
    .s (s_c0),
    .co(co_c0)
  );

  csel_ripple #(.W(W)) u_one (
    .x (x),
    .y (y),
    .ci(1'b1),
    .s (s_c1),
    .co(co_c1)
  );

  logic [W:0] total_c0;
  logic [W:0] total_c1;
  assign total_c0 = {co_c0, s_c0};
  assign total_c1 = {co_c1, s_c1};

  // The carry-one candidate is always one above the carry-zero candidate (R4).
  always_comb begin
    assert_pair_step_R4: assert (total_c1 == total_c0 + (W+1)'(1))
      else $error("R4: candidate pair not one apart");
  end

  // A carry out with carry-in 0 implies a carry out with carry-in 1 (R5).
  always_comb begin
    assert_carry_order_R5: assert (!co_c0 || co_c1)
      else $error("R5: carry candidates out of order");
  end

endmodule

// File: rtl/csel_pick.sv
module csel_pick #(
  parameter int W = 8
) (
  input  logic         sel,
  input  logic [W-1:0] s_c0,
  input  logic         co_c0,
  input  logic [W-1:0] s_c1,
  input  logic         co_c1,
  output logic [W-1:0] s,
  output logic         co
);

  always_comb begin
    if (sel) begin
      s  = s_c1;
      co = co_c1;
    end else begin
      s  = s_c0;
      co = co_c0;
    end
  end

endmodule

// File: rtl/csel_adder32.sv
module csel_adder32
  import csel_adder_pkg::*;
#(
  parameter int BASE    = 4,
  parameter int NFIELDS = 4
) (
  input  logic [31:0] a,
  input  logic [31:0] b,
  input  logic        cin,
  output logic [31:0] sum,
  output logic        cout
);

  localparam int WORD = word_width(NFIELDS, BASE);

  logic [NFIELDS:0] fcarry;
  logic [WORD-1:0]  opa;
  logic [WORD-1:0]  opb;
  logic [WORD-1:0]  res;

  assign opa       = WORD'(a);
  assign opb       = WORD'(b);
  assign fcarry[0] = cin;

  for (genvar k = 0; k < NFIELDS; k++) begin : g_field
    localparam int FW  = field_width(k, BASE);
    localparam int LSB = field_lsb(k, BASE);

    if (k == 0) begin : g_low
      csel_ripple #(.W(FW)) u_low (
        .x (opa[LSB +: FW]),
        .y (opb[LSB +: FW]),
        .ci(fcarry[0]),
        .s (res[LSB +: FW]),
        .co(fcarry[1])
      );
    end else begin : g_up
      logic [FW-1:0] s0;
      logic [FW-1:0] s1;
      logic          c0;
      logic          c1;

      csel_dual_field #(.W(FW)) u_dual (
        .x    (opa[LSB +: FW]),
        .y    (opb[LSB +: FW]),
        .s_c0 (s0),
        .co_c0(c0),
        .s_c1 (s1),
        .co_c1(c1)
      );

      csel_pick #(.W(FW)) u_pick (
        .sel  (fcarry[k]),
        .s_c0 (s0),
        .co_c0(c0),
        .s_c1 (s1),
        .co_c1(c1),
        .s    (res[LSB +: FW]),
        .co   (fcarry[k+1])
      );
    end
  end

  assign sum  = res[31:0];
  assign cout = fcarry[NFIELDS];

  // Whole result against a behavioural addition (R1).
  always_comb begin
    assert_total_R1: assert ({cout, sum} == {1'b0, a} + {1'b0, b} + 33'(cin))
      else $error("R1: sum mismatch");
  end

  // The low field sees only its own bits and cin (R2).
  always_comb begin
    assert_low_field_R2: assert (sum[3:0] == 4'(a[3:0] + b[3:0] + 4'(cin)))
      else $error("R2: low field mismatch");
  end

endmodule

// File: tb/csel_adder32_test.sv
module csel_adder32_test;

  logic        clk = 1'b0;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic        cin = 1'b0;
  logic [31:0] sum;
  logic        cout;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  csel_adder32 uut (
    .a   (a),
    .b   (b),
    .cin (cin),
    .sum (sum),
    .cout(cout)
  );

  // Drive just after a rising edge, check at the next falling edge (R9: zero cycles).
  task automatic apply(input logic [31:0] va, input logic [31:0] vb,
                       input logic vc, input string req);
    logic [32:0] expv;
    @(posedge clk);
    #1;
    a   = va;
    b   = vb;
    cin = vc;
    expv = {1'b0, va} + {1'b0, vb} + 33'(vc);
    @(negedge clk);
    checks++;
    if ({cout, sum} !== expv) begin
      errors++;
      $display("FAIL %s: a=%h b=%h cin=%0d got cout=%0d sum=%h expected cout=%0d sum=%h",
               req, va, vb, vc, cout, sum, expv[32], expv[31:0]);
    end
  endtask

  task automatic expect_low(input logic [3:0] want, input string req);
    checks++;
    if (sum[3:0] !== want) begin
      errors++;
      $display("FAIL %s: sum[3:0]=%h expected %h", req, sum[3:0], want);
    end
  endtask

  initial begin
    // R8: all-zero inputs, then carry-in only.
    apply(32'h0, 32'h0, 1'b0, "R8");
    apply(32'h0, 32'h0, 1'b1, "R8");

    // R6 and R7: wrap to zero with carry out.
    apply(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R6");
    apply(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, "R7");

    // R3: carries crossing each field boundary.
    apply(32'h0000_000F, 32'h0000_0001, 1'b0, "R3");
    apply(32'h0000_00FF, 32'h0000_0001, 1'b0, "R3");
    apply(32'h0000_00F0, 32'h0000_0010, 1'b0, "R3");
    apply(32'h0000_FF00, 32'h0000_0100, 1'b0, "R3");
    apply(32'h0000_0007, 32'h0000_0008, 1'b1, "R3");

    // R4: carry rippling through the whole wide fields.
    apply(32'h0000_FFFF, 32'h0000_0001, 1'b0, "R4");
    apply(32'h00FF_FF00, 32'h0000_0100, 1'b0, "R4");
    apply(32'h7FFF_0000, 32'h0001_0000, 1'b0, "R4");

    // R5: carry out from the top field alone, and its absence.
    apply(32'h8000_0000, 32'h8000_0000, 1'b0, "R5");
    apply(32'h8000_0000, 32'h7FFF_FFFF, 1'b0, "R5");
    apply(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, "R5");

    // R2: upper bits must not disturb the low field.
    apply(32'h0000_0009, 32'h0000_0008, 1'b1, "R2");
    expect_low(4'h2, "R2");
    apply(32'hABCD_1239, 32'h5A5A_A5A8, 1'b1, "R2");
    expect_low(4'h2, "R2");

    // R1: random operands, both carry-in values.
    for (int i = 0; i < 2000; i++) begin
      apply($urandom, $urandom, 1'($urandom), "R1");
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule